// File: doc/BRIEF.md
# PWM Dead-Band Generator

This block sits between a PWM waveform source and the gate drivers of a half bridge. It takes two raw PWM signals, A and B, and produces an output pair whose edges have been moved apart. The upper and lower switches are never driven on together. A rising-edge delay path holds back the turn-on edge of the upper drive. A falling-edge delay path stretches the turn-off edge of the lower-side signal. Both delays are counted in cycles of the time-base clock. The dead time is therefore the delay count multiplied by the clock period: at 50 MHz, a count of 160 gives 3.2 us.

Three small control fields shape the routing:
- An input-source field chooses whether A or B feeds each of the two delay paths.
- An output-mode field chooses, for each output, whether it comes from its delay path or straight from its own input. Full bypass is one of these choices.
- A polarity field can invert the signal coming out of either delay path.

With these fields the block can pass the pair through untouched, delay only one side, or build the classic complementary pair from a single source. The settings act combinationally. A change applies in the cycle it is made, and the delay counters keep tracking whichever source is routed to them.

Top module: `pwm_deadband`

## Requirements
- R1: While reset is asserted, the rising path acts as if its source has been low for a long time, so its output is low. The falling path acts the same way, so its output simply follows its source. With both inputs low, both outputs are therefore low.
- R2: Output mode 2'b00 is full bypass. The A output equals the A input and the B output equals the B input in the same cycle, whatever the polarity and input-source settings are.
- R3: Output mode 2'b11 drives the A output from the rising-delay path and the B output from the falling-delay path. Each passes through its polarity stage first.
- R4: Output mode 2'b01 drives the A output straight from the A input and the B output from the falling-delay path. Output mode 2'b10 drives the A output from the rising-delay path and the B output straight from the B input.
- R5: Input-source bit 0 set to 1 feeds input B to the rising-delay path, and set to 0 feeds A. Bit 1 makes the same choice for the falling-delay path. The four encodings are: 0 gives A to both, 1 gives B rise / A fall, 2 gives A rise / B fall, 3 gives B to both.
- R6: Polarity bit 0 inverts the rising-path signal on its way to output A. Polarity bit 1 inverts the falling-path signal on its way to output B. An output taken straight from its input is never inverted.
- R7: With a rising delay of D, the rising-path output is high in a cycle only when its source is high in that cycle and in each of the D cycles before it, counted since reset. Turn-on is thus delayed by exactly D clock periods.
- R8: With a falling delay of D, the falling-path output is low in a cycle only when its source is low in that cycle and in each of the D cycles before it. Turn-off is thus delayed by exactly D clock periods.
- R9: A high pulse of W cycles on the rising path is swallowed when W is at most D, and otherwise appears W−D cycles wide. A low pulse on the falling path is treated the same way against its own delay.
- R10: A delay value of 0 makes that path a same-cycle passthrough of its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock; delays are counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_a_in | input | 1 | Raw PWM signal A |
| pwm_b_in | input | 1 | Raw PWM signal B |
| rise_dly | input | 10 | Rising-edge delay in clock cycles |
| fall_dly | input | 10 | Falling-edge delay in clock cycles |
| in_sel | input | 2 | Delay path source select (bit 0: rising path, bit 1: falling path; 1 = B) |
| out_sel | input | 2 | Output mode (bit 1: A from rising path, bit 0: B from falling path) |
| pol_sel | input | 2 | Polarity (bit 0: invert rising path, bit 1: invert falling path) |
| pwm_a_out | output | 1 | Conditioned A output |
| pwm_b_out | output | 1 | Conditioned B output |

## Verification
The sharpest corner comes when the end of a source pulse lands in the same cycle as the expiry of its delay count. In that cycle the edge of the source and the completion of the delay compete. The bench provokes this with high pulses of exactly D and D+1 cycles and low gaps of exactly the falling delay and one more. The first must vanish and the second must leave a single-cycle pulse. A behavioural model keeps a history queue of each routed source and judges every cycle against it. It also changes the routing and polarity fields in the middle of a pulse stream, so that a settings change and an edge fall in the same cycle.

// File: rtl/db_pkg.sv
package db_pkg;

  typedef enum logic [1:0] {
    OUTM_PASS   = 2'b00,
    OUTM_B_FALL = 2'b01,
    OUTM_A_RISE = 2'b10,
    OUTM_BOTH   = 2'b11
  } out_mode_e;

  // Pick A or B for one delay path.
  function automatic logic pick_src(input logic use_b, input logic a, input logic b);
    return use_b ? b : a;
  endfunction

  // Rising path: high only after the hold time elapsed.
  function automatic logic hold_rise(input logic din, input logic settled);
    return din & settled;
  endfunction

  // Falling path: low only after the hold time elapsed.
  function automatic logic hold_fall(input logic din, input logic settled);
    return din | ~settled;
  endfunction

  function automatic logic apply_pol(input logic sig, input logic inv);
    return sig ^ inv;
  endfunction

endpackage

// File: rtl/db_src_mux.sv
module db_src_mux
  import db_pkg::*;
(
  input  logic       a_in,
  input  logic       b_in,
  input  logic [1:0] in_sel,
  output logic       red_src,
  output logic       fed_src
);

  logic [1:0] path_src;

  for (genvar p = 0; p < 2; p++) begin : g_path
    assign path_src[p] = pick_src(in_sel[p], a_in, b_in);
  end

  assign red_src = path_src[0];
  assign fed_src = path_src[1];

endmodule

// File: rtl/db_edge_delay.sv
module db_edge_delay
  import db_pkg::*;
#(
  parameter int unsigned CNT_W = 10,
  parameter bit          RISE  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [CNT_W-1:0] dly,
  output logic             dout,
  output logic             settled
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_RST = RISE ? {CNT_W{1'b0}} : CNT_MAX;

  logic [CNT_W-1:0] run_cnt;
  logic             active;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  // Length of the current run at the level that arms the delay.
  assign active = RISE ? din : ~din;

  always_ff @(posedge clk) begin
    if (!rst_n)      run_cnt <= CNT_RST;
    else if (active) run_cnt <= sat_inc(run_cnt);
    else             run_cnt <= '0;
  end

  assign settled = (run_cnt >= dly);

  if (RISE) begin : g_rise
    assign dout = hold_rise(din, settled);
  end else begin : g_fall
    assign dout = hold_fall(din, settled);
  end

endmodule

// File: rtl/db_out_stage.sv
module db_out_stage
  import db_pkg::*;
(
  input  logic       a_in,
  input  logic       b_in,
  input  logic       red_dly,
  input  logic       fed_dly,
  input  logic [1:0] out_sel,
  input  logic [1:0] pol_sel,
  output logic       red_pol,
  output logic       fed_pol,
  output logic       a_out,
  output logic       b_out
);

  out_mode_e mode;

  assign mode    = out_mode_e'(out_sel);
  assign red_pol = apply_pol(red_dly, pol_sel[0]);
  assign fed_pol = apply_pol(fed_dly, pol_sel[1]);

  always_comb begin
    unique case (mode)
      OUTM_PASS:   begin a_out = a_in;    b_out = b_in;    end
      OUTM_B_FALL: begin a_out = a_in;    b_out = fed_pol; end
      OUTM_A_RISE: begin a_out = red_pol; b_out = b_in;    end
      default:     begin a_out = red_pol; b_out = fed_pol; end
    endcase
  end

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
  import db_pkg::*;
#(
  parameter int unsigned DLY_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_a_in,
  input  logic             pwm_b_in,
  input  logic [DLY_W-1:0] rise_dly,
  input  logic [DLY_W-1:0] fall_dly,
  input  logic [1:0]       in_sel,
  input  logic [1:0]       out_sel,
  input  logic [1:0]       pol_sel,
  output logic             pwm_a_out,
  output logic             pwm_b_out
);

  logic red_src, fed_src;
  logic red_dly, fed_dly;
  logic red_settled, fed_settled;
  logic red_pol, fed_pol;

  db_src_mux u_src (
    .a_in   (pwm_a_in),
    .b_in   (pwm_b_in),
    .in_sel (in_sel),
    .red_src(red_src),
    .fed_src(fed_src)
  );

  db_edge_delay #(.CNT_W(DLY_W), .RISE(1'b1)) u_red (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (red_src),
    .dly    (rise_dly),
    .dout   (red_dly),
    .settled(red_settled)
  );

  db_edge_delay #(.CNT_W(DLY_W), .RISE(1'b0)) u_fed (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (fed_src),
    .dly    (fall_dly),
    .dout   (fed_dly),
    .settled(fed_settled)
  );

  db_out_stage u_out (
    .a_in   (pwm_a_in),
    .b_in   (pwm_b_in),
    .red_dly(red_dly),
    .fed_dly(fed_dly),
    .out_sel(out_sel),
    .pol_sel(pol_sel),
    .red_pol(red_pol),
    .fed_pol(fed_pol),
    .a_out  (pwm_a_out),
    .b_out  (pwm_b_out)
  );

endmodule

// File: rtl/db_checker.sv
module db_checker #(
  parameter int unsigned DLY_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_a_in,
  input logic             pwm_b_in,
  input logic [DLY_W-1:0] rise_dly,
  input logic [DLY_W-1:0] fall_dly,
  input logic [1:0]       out_sel,
  input logic             red_src,
  input logic             fed_src,
  input logic             red_dly,
  input logic             fed_dly,
  input logic             pwm_a_out,
  input logic             pwm_b_out
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel == 2'b00) |-> (pwm_a_out == pwm_a_in && pwm_b_out == pwm_b_in));

  p_direct_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel == 2'b01) |-> (pwm_a_out == pwm_a_in));

  p_direct_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel == 2'b10) |-> (pwm_b_out == pwm_b_in));

  p_rise_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    red_dly |-> red_src);

  p_rise_hist_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(red_dly) && rise_dly != '0) |-> $past(red_src));

  p_fall_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fed_src |-> fed_dly);

  p_fall_hist_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $fell(fed_dly) && fall_dly != '0) |-> !$past(fed_src));

  p_zero_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_dly == '0) |-> (red_dly == red_src));

  p_zero_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_dly == '0) |-> (fed_dly == fed_src));

endmodule

bind pwm_deadband db_checker #(.DLY_W(DLY_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwm_a_in (pwm_a_in),
  .pwm_b_in (pwm_b_in),
  .rise_dly (rise_dly),
  .fall_dly (fall_dly),
  .out_sel  (out_sel),
  .red_src  (red_src),
  .fed_src  (fed_src),
  .red_dly  (red_dly),
  .fed_dly  (fed_dly),
  .pwm_a_out(pwm_a_out),
  .pwm_b_out(pwm_b_out)
);

// File: tb/pwm_deadband_bench.sv
`timescale 1ns/1ps
module pwm_deadband_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwm_a_in, pwm_b_in;
  logic [9:0] rise_dly, fall_dly;
  logic [1:0] in_sel, out_sel, pol_sel;
  logic       pwm_a_out, pwm_b_out;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  bit    rq[$];
  bit    fq[$];

  always #2.5 clk = ~clk;

  pwm_deadband u_pwm_deadband (
    .clk(clk), .rst_n(rst_n), .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
    .rise_dly(rise_dly), .fall_dly(fall_dly), .in_sel(in_sel),
    .out_sel(out_sel), .pol_sel(pol_sel),
    .pwm_a_out(pwm_a_out), .pwm_b_out(pwm_b_out)
  );

  // Rising path: current and the last d samples all high (missing = low).
  function automatic bit model_rise(bit cur, int d);
    if (d == 0) return cur;
    if (!cur || rq.size() < d) return 1'b0;
    for (int i = rq.size() - d; i < rq.size(); i++) if (!rq[i]) return 1'b0;
    return 1'b1;
  endfunction

  // Falling path: high if current or any of the last d samples high.
  function automatic bit model_fall(bit cur, int d);
    int lo;
    if (cur || d == 0) return cur;
    lo = (fq.size() > d) ? fq.size() - d : 0;
    for (int i = lo; i < fq.size(); i++) if (fq[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check_cycle(bit in_reset);
    bit rs, fs, ea, eb;
    rs = in_sel[0] ? pwm_b_in : pwm_a_in;
    fs = in_sel[1] ? pwm_b_in : pwm_a_in;
    if (in_reset) begin
      ea = 1'b0;  // R1: rising path idle in reset
      eb = fs;    // R1: falling path follows its source
      if (out_sel != 2'b11 || pol_sel != 2'b00) begin ea = 1'bx; end
    end else begin
      ea = out_sel[1] ? (model_rise(rs, int'(rise_dly)) ^ pol_sel[0]) : pwm_a_in;
      eb = out_sel[0] ? (model_fall(fs, int'(fall_dly)) ^ pol_sel[1]) : pwm_b_in;
    end
    n_chk++;
    if (pwm_a_out !== ea) begin
      n_fail++;
      $display("FAIL %s pwm_a_out t=%0t actual=%b expected=%b", cur_req, $time, pwm_a_out, ea);
    end
    n_chk++;
    if (pwm_b_out !== eb) begin
      n_fail++;
      $display("FAIL %s pwm_b_out t=%0t actual=%b expected=%b", cur_req, $time, pwm_b_out, eb);
    end
    if (!in_reset) begin
      rq.push_back(rs);
      fq.push_back(fs);
      if (rq.size() > 1100) void'(rq.pop_front());
      if (fq.size() > 1100) void'(fq.pop_front());
    end
  endtask

  task automatic step(bit a, bit b);
    pwm_a_in = a;
    pwm_b_in = b;
    @(negedge clk);
    check_cycle(!rst_n);
    @(posedge clk);
    #1;
  endtask

  task automatic pulse(int hi, int lo);
    repeat (hi) step(1'b1, 1'b0);
    repeat (lo) step(1'b0, 1'b0);
  endtask

  task automatic square(int n, int per, bit rnd_b);
    for (int i = 0; i < n; i++) begin
      bit a;
      a = (i % per) < (per / 2);
      step(a, rnd_b ? 1'($urandom) : ~a);
    end
  endtask

  task automatic set_cfg(bit [1:0] os, bit [1:0] is, bit [1:0] ps, int r, int f);
    out_sel  = os;
    in_sel   = is;
    pol_sel  = ps;
    rise_dly = 10'(r);
    fall_dly = 10'(f);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    set_cfg(2'b11, 2'b00, 2'b00, 4, 3);
    pwm_a_in = 1'b0;
    pwm_b_in = 1'b0;
    @(posedge clk); #1;
    // R1: reset state with both inputs low
    cur_req = "R1";
    repeat (3) step(1'b0, 1'b0);
    rst_n = 1'b1;
    rq.delete();
    fq.delete();

    // R3, R7, R8, R9: classic pair from A, pulse widths around the delays
    cur_req = "R3/R7/R8/R9";
    pulse(12, 10);
    pulse(3, 10);   // R9: shorter than rise delay
    pulse(4, 10);   // R9: equal to rise delay, swallowed
    pulse(5, 10);   // R9: one cycle survives
    pulse(12, 2);   // R9: low gap below fall delay
    pulse(12, 3);   // R9: low gap equal to fall delay
    pulse(12, 4);   // R9: one low cycle survives
    pulse(1, 12);

    // R6: polarity variants
    cur_req = "R6";
    set_cfg(2'b11, 2'b00, 2'b01, 3, 5); square(48, 16, 1'b0);
    set_cfg(2'b11, 2'b00, 2'b10, 3, 5); square(48, 16, 1'b0);
    set_cfg(2'b11, 2'b00, 2'b11, 3, 5); square(48, 16, 1'b0);

    // R5: input source routing
    cur_req = "R5";
    set_cfg(2'b11, 2'b01, 2'b00, 2, 4); square(56, 14, 1'b1);
    set_cfg(2'b11, 2'b10, 2'b00, 2, 4); square(56, 14, 1'b1);
    set_cfg(2'b11, 2'b11, 2'b01, 2, 4); square(56, 14, 1'b1);

    // R4: one-sided modes, polarity must not touch the direct output
    cur_req = "R4";
    set_cfg(2'b01, 2'b00, 2'b11, 6, 3); square(64, 20, 1'b1);
    set_cfg(2'b10, 2'b00, 2'b11, 6, 3); square(64, 20, 1'b1);

    // R2: bypass ignores polarity and routing
    cur_req = "R2";
    set_cfg(2'b00, 2'b11, 2'b11, 7, 7);
    for (int i = 0; i < 64; i++) step(1'($urandom), 1'($urandom));

    // R10: zero delays
    cur_req = "R10";
    set_cfg(2'b11, 2'b10, 2'b00, 0, 0);
    for (int i = 0; i < 48; i++) step(1'($urandom), 1'($urandom));
    set_cfg(2'b11, 2'b00, 2'b00, 0, 5); square(40, 10, 1'b0);

    // R7, R8: long dead times and a mid-stream settings change
    cur_req = "R7/R8";
    set_cfg(2'b11, 2'b00, 2'b00, 300, 200); square(2000, 1000, 1'b0);
    set_cfg(2'b11, 2'b00, 2'b00, 1023, 1023); square(1200, 2400, 1'b0);
    cur_req = "R3/R5/R6";
    set_cfg(2'b11, 2'b00, 2'b00, 3, 3);
    for (int i = 0; i < 200; i++) begin
      if (i % 37 == 0) begin
        in_sel  = 2'($urandom);
        pol_sel = 2'($urandom);
      end
      step(1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule